// File: doc/BRIEF.md
# Queue Doorbell Address Decoder

This block sits behind a device's notification register window and turns incoming register-bus writes into per-queue "buffer available" notifications. Every queue owns a programmable slot index. The index counts slots, not bytes: a shared multiplier scales it into a byte offset inside the window. A write whose address lands on an enabled queue's slot produces a single-cycle notify strobe. The strobe carries the queue number and the 16-bit value that was written.

The multiplier is given either as a shift code or as a zero-multiplier flag. With the flag set, every queue shares one doorbell at offset zero, and the written value names the queue. A write that hits no slot, that leaves part of the addressed halfword unwritten, or that names a queue that is absent or disabled produces no notification.

Top module: `nfy_doorbell_dec`

## Requirements
- R1: After reset `notifyValid` is low. It stays low until an accepted write has been sampled.
- R2: With `mulZero` low, queue q's doorbell sits at byte offset idx_q × (2 << `mulShift`). The field idx_q is bits [q*IDX_W +: IDX_W] of `qSlotIdx`. A write to exactly that address raises `notifyValid` in the cycle after the write is sampled, with `notifyQueue` = q.
- R3: `notifyData` is the little-endian halfword at the written address. It is `wrData[15:0]` when `wrAddr[1]` is 0 and `wrData[31:16]` when `wrAddr[1]` is 1.
- R4: A queue whose bit in `qEnable` is 0 never produces a notification, in either mode.
- R5: When the multiplier is nonzero and several enabled queues share the written slot, the lowest-numbered of them is reported.
- R6: A write whose address matches no enabled slot, including an odd address, is ignored: no strobe follows it.
- R7: A write is accepted only if both byte enables of the addressed halfword are set. These are `wrStrb[1:0]` for the low halfword and `wrStrb[3:2]` for the high halfword. Otherwise it is ignored.
- R8: With `mulZero` high, only a write to address 0 can notify. The 16-bit written value is the queue number, and it is reported both as `notifyQueue` and as `notifyData`.
- R9: With `mulZero` high, the full 16-bit written value is compared against the queue count. A value of at least NUM_QUEUES, or one that names a disabled queue, is ignored.
- R10: Each accepted write gives exactly one strobe cycle. Writes on consecutive cycles give strobes on consecutive cycles, in order.
- R11: A slot whose byte offset does not fit in ADDR_W bits is never matched. In particular, it does not alias to its truncated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Write transaction present this cycle |
| wrAddr | input | ADDR_W | Byte address inside the notification window |
| wrData | input | 32 | Write data, little-endian |
| wrStrb | input | 4 | Byte enables, bit n for byte lane n |
| mulZero | input | 1 | Zero-multiplier (shared doorbell) mode |
| mulShift | input | SHIFT_W | Multiplier code: multiplier = 2 << mulShift |
| qEnable | input | NUM_QUEUES | Per-queue enable |
| qSlotIdx | input | NUM_QUEUES*IDX_W | Per-queue slot index, queue q at [q*IDX_W +: IDX_W] |
| notifyValid | output | 1 | One-cycle notification strobe |
| notifyQueue | output | QID_W | Queue number of the notification |
| notifyData | output | 16 | Halfword written to the doorbell |

## Verification
The bench builds the block with NUM_QUEUES=5, IDX_W=8, SHIFT_W=3 and ADDR_W=12. Five queues leave the 3-bit queue field with values 5 to 7 that name no queue, so the range check of the shared mode can be reached, and so can a 16-bit value whose low bits would alias a real queue. The 12-bit address, together with an index of 255 and the largest shift, places a slot at 65280. That slot lies beyond the window, so a write to its truncated address must stay silent. Two queues are given the same index to exercise the tie rule.

// File: rtl/nfy_pkg.sv
package nfy_pkg;
  localparam int DATA_W  = 32;
  localparam int STRB_W  = DATA_W / 8;
  localparam int HALF_W  = 16;
  localparam int QID_MAX = 8;

  typedef struct packed {
    logic               fire;
    logic [QID_MAX-1:0] qid;
  } nfy_ctrl_t;
endpackage

// File: rtl/nfy_slot_match.sv
module nfy_slot_match #(
  parameter int IDX_W   = 8,
  parameter int SHIFT_W = 3,
  parameter int ADDR_W  = 12
) (
  input  logic [IDX_W-1:0]   slotIdx,
  input  logic [SHIFT_W-1:0] shiftCode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               enable,
  output logic               hit
);
  localparam int OFF_W = IDX_W + (1 << SHIFT_W) + ADDR_W;

  logic [OFF_W-1:0] slotOffset;
  logic [SHIFT_W:0] shiftAmt;

  always_comb begin
    shiftAmt   = {1'b0, shiftCode} + 1'b1;
    slotOffset = OFF_W'(slotIdx) << shiftAmt;
    hit        = enable && (slotOffset == OFF_W'(addr));
  end
endmodule

// File: rtl/nfy_ctrl.sv
module nfy_ctrl
  import nfy_pkg::*;
#(
  parameter int NUM_QUEUES = 8,
  parameter int IDX_W      = 8,
  parameter int SHIFT_W    = 3,
  parameter int ADDR_W     = 12,
  localparam int QID_W     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wrValid,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [STRB_W-1:0]           wrStrb,
  input  logic                        mulZero,
  input  logic [SHIFT_W-1:0]          mulShift,
  input  logic [NUM_QUEUES-1:0]       qEnable,
  input  logic [NUM_QUEUES*IDX_W-1:0] qSlotIdx,
  input  logic [HALF_W-1:0]           laneValue,
  output nfy_ctrl_t                   ctrl
);
  localparam int PAD_N = 1 << QID_W;

  logic [NUM_QUEUES-1:0] hitVec;
  logic [PAD_N-1:0]      enPad;
  logic [QID_W-1:0]      pickIdx;
  logic                  anyHit;
  logic                  laneOk;
  logic                  sharedHit;

  genvar gq;
  generate
    for (gq = 0; gq < NUM_QUEUES; gq++) begin : g_slot
      nfy_slot_match #(
        .IDX_W(IDX_W), .SHIFT_W(SHIFT_W), .ADDR_W(ADDR_W)
      ) slot_i (
        .slotIdx  (qSlotIdx[gq*IDX_W +: IDX_W]),
        .shiftCode(mulShift),
        .addr     (wrAddr),
        .enable   (qEnable[gq]),
        .hit      (hitVec[gq])
      );
    end
  endgenerate

  always_comb begin
    enPad = '0;
    enPad[NUM_QUEUES-1:0] = qEnable;
  end

  always_comb begin
    pickIdx = '0;
    anyHit  = 1'b0;
    for (int i = NUM_QUEUES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        pickIdx = QID_W'(i);
        anyHit  = 1'b1;
      end
    end
  end

  always_comb begin
    laneOk    = wrAddr[1] ? (wrStrb[3] && wrStrb[2]) : (wrStrb[1] && wrStrb[0]);
    sharedHit = (wrAddr == '0) && (laneValue < HALF_W'(NUM_QUEUES))
                && enPad[laneValue[QID_W-1:0]];
    ctrl.fire = wrValid && laneOk && (mulZero ? sharedHit : anyHit);
    ctrl.qid  = '0;
    ctrl.qid[QID_W-1:0] = mulZero ? laneValue[QID_W-1:0] : pickIdx;
  end

  a_r4_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire |-> enPad[ctrl.qid[QID_W-1:0]]);

  a_r7_full_halfword: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire |-> (wrAddr[1] ? (wrStrb[3:2] == 2'b11) : (wrStrb[1:0] == 2'b11)));

  a_r8_shared_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.fire && mulZero) |-> (wrAddr == '0));

  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.fire && !mulZero) |->
      (hitVec[ctrl.qid[QID_W-1:0]] &&
       ((hitVec & ((NUM_QUEUES'(1) << ctrl.qid[QID_W-1:0]) - 1'b1)) == '0)));

  a_r6_even_address: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire |-> !wrAddr[0]);
endmodule

// File: rtl/nfy_datapath.sv
module nfy_datapath
  import nfy_pkg::*;
#(
  parameter int QID_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              laneSel,
  input  logic [DATA_W-1:0] wrData,
  input  nfy_ctrl_t         ctrl,
  output logic [HALF_W-1:0] laneValue,
  output logic              notifyValid,
  output logic [QID_W-1:0]  notifyQueue,
  output logic [HALF_W-1:0] notifyData
);
  always_comb laneValue = laneSel ? wrData[31:16] : wrData[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notifyValid <= 1'b0;
      notifyQueue <= '0;
      notifyData  <= '0;
    end else begin
      notifyValid <= ctrl.fire;
      if (ctrl.fire) begin
        notifyQueue <= ctrl.qid[QID_W-1:0];
        notifyData  <= laneValue;
      end
    end
  end

  a_r10_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire |=> notifyValid);

  a_r10_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.fire |=> !notifyValid);

  a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.fire |=> $stable(notifyData));
endmodule

// File: rtl/nfy_doorbell_dec.sv
module nfy_doorbell_dec
  import nfy_pkg::*;
#(
  parameter int NUM_QUEUES = 8,
  parameter int IDX_W      = 8,
  parameter int SHIFT_W    = 3,
  parameter int ADDR_W     = 12,
  localparam int QID_W     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wrValid,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [31:0]                 wrData,
  input  logic [3:0]                  wrStrb,
  input  logic                        mulZero,
  input  logic [SHIFT_W-1:0]          mulShift,
  input  logic [NUM_QUEUES-1:0]       qEnable,
  input  logic [NUM_QUEUES*IDX_W-1:0] qSlotIdx,
  output logic                        notifyValid,
  output logic [QID_W-1:0]            notifyQueue,
  output logic [15:0]                 notifyData
);
  nfy_ctrl_t   ctrl;
  logic [15:0] laneValue;

  nfy_ctrl #(
    .NUM_QUEUES(NUM_QUEUES), .IDX_W(IDX_W), .SHIFT_W(SHIFT_W), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrStrb(wrStrb), .mulZero(mulZero), .mulShift(mulShift),
    .qEnable(qEnable), .qSlotIdx(qSlotIdx), .laneValue(laneValue),
    .ctrl(ctrl)
  );

  nfy_datapath #(.QID_W(QID_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .laneSel(wrAddr[1]), .wrData(wrData),
    .ctrl(ctrl), .laneValue(laneValue), .notifyValid(notifyValid),
    .notifyQueue(notifyQueue), .notifyData(notifyData)
  );
endmodule

// File: tb/nfy_doorbell_dec_tb.sv
module nfy_doorbell_dec_tb_top;
  localparam int NQ = 5, IW = 8, SW = 3, AW = 12, QW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrValid = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [31:0]   wrData = '0;
  logic [3:0]    wrStrb = '0;
  logic          mulZero = 1'b0;
  logic [SW-1:0] mulShift = '0;
  logic [NQ-1:0] qEnable = '1;
  logic [NQ*IW-1:0] qSlotIdx;
  logic          notifyValid;
  logic [QW-1:0] notifyQueue;
  logic [15:0]   notifyData;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  nfy_doorbell_dec #(.NUM_QUEUES(NQ), .IDX_W(IW), .SHIFT_W(SW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrStrb(wrStrb), .mulZero(mulZero), .mulShift(mulShift),
    .qEnable(qEnable), .qSlotIdx(qSlotIdx), .notifyValid(notifyValid),
    .notifyQueue(notifyQueue), .notifyData(notifyData)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic expectNone(input string tag);
    check(notifyValid == 1'b0, tag, "valid", notifyValid, 0);
  endtask

  task automatic expectHit(input string tag, input int q, input int d);
    check(notifyValid == 1'b1, tag, "valid", notifyValid, 1);
    check(notifyQueue == q, tag, "queue", notifyQueue, q);
    check(notifyData == d, tag, "data", notifyData, d);
  endtask

  // drive at negedge, design samples at posedge, result visible at next negedge
  task automatic doWrite(input int a, input logic [31:0] d, input logic [3:0] s);
    wrAddr = AW'(a); wrData = d; wrStrb = s; wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic tReset;
    expectNone("R1");
    @(negedge clk);
    expectNone("R1");
  endtask

  task automatic tBasic;
    mulZero = 0; mulShift = 0;
    doWrite(2, 32'h1234_ABCD, 4'hF); expectHit("R2", 0, 16'h1234);
    doWrite(20, 32'h9999_BEEF, 4'hF); expectHit("R3", 3, 16'hBEEF);
    @(negedge clk); expectNone("R10");
  endtask

  task automatic tTie;
    doWrite(6, 32'h5678_0000, 4'hF); expectHit("R5", 1, 16'h5678);
    qEnable[1] = 0;
    doWrite(6, 32'h4321_0000, 4'hF); expectHit("R5", 2, 16'h4321);
    qEnable[1] = 1;
  endtask

  task automatic tMiss;
    mulShift = 2;
    doWrite(80, 32'h0000_0042, 4'hF); expectHit("R2", 3, 16'h0042);
    doWrite(20, 32'h0000_0042, 4'hF); expectNone("R6");
    doWrite(81, 32'h0000_0042, 4'hF); expectNone("R6");
  endtask

  task automatic tStrobes;
    doWrite(80, 32'h0000_0011, 4'b0001); expectNone("R7");
    doWrite(80, 32'h0000_0011, 4'b1100); expectNone("R7");
    doWrite(80, 32'h0000_0011, 4'b0011); expectHit("R7", 3, 16'h0011);
  endtask

  task automatic tWide;
    mulShift = 7;
    doWrite(3840, 32'h0000_0077, 4'hF); expectNone("R11");
    doWrite(2560, 32'h0000_0077, 4'hF); expectHit("R11", 3, 16'h0077);
    qEnable[3] = 0;
    doWrite(2560, 32'h0000_0077, 4'hF); expectNone("R4");
    qEnable[3] = 1;
  endtask

  task automatic tBackToBack;
    wrAddr = 256; wrData = 32'h0000_00A1; wrStrb = 4'hF; wrValid = 1;
    @(negedge clk);
    wrAddr = 768; wrData = 32'h0000_00B2;
    expectHit("R10", 0, 16'h00A1);
    @(negedge clk);
    wrValid = 0;
    expectHit("R10", 1, 16'h00B2);
    @(negedge clk);
    expectNone("R10");
  endtask

  task automatic tShared;
    mulZero = 1;
    doWrite(0, 32'h0000_0003, 4'b0011); expectHit("R8", 3, 3);
    doWrite(2, 32'h0002_0000, 4'b1100); expectNone("R8");
    doWrite(256, 32'h0000_0000, 4'hF); expectNone("R8");
    doWrite(0, 32'h0000_0007, 4'b0011); expectNone("R9");
    doWrite(0, 32'h0000_0104, 4'b0011); expectNone("R9");
    qEnable[4] = 0;
    doWrite(0, 32'h0000_0004, 4'b0011); expectNone("R9");
    qEnable[4] = 1;
    doWrite(0, 32'h0000_0004, 4'b0011); expectHit("R8", 4, 4);
    qEnable[0] = 0;
    doWrite(0, 32'h0000_0000, 4'b0011); expectNone("R4");
    qEnable[0] = 1;
  endtask

  bit done = 0;

  initial begin
    qSlotIdx = {8'd255, 8'd10, 8'd3, 8'd3, 8'd1};
    @(negedge clk); @(negedge clk);
    tReset();
    rst_n = 1;
    @(negedge clk);
    tReset();
    tBasic();
    tTie();
    tMiss();
    tStrobes();
    tWide();
    tBackToBack();
    tShared();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule